// File: doc/BRIEF.md
# Boundary Scan Register with Tri-State Pin Control

This block is the boundary data register of a memory device's test port. It has 113 cells. A test access port controller drives it with capture, shift and update strobes and a mode code. In a capture cycle every cell loads a value from its pin or its source. Shift cycles then move the chain one cell toward the serial output on each clock. An update strobe copies the chain into a set of update latches, and those latches drive the device pins whenever a test mode is selected.

The chain has several kinds of cell. Input-only cells watch address, bank, command, clock and mask pins; they capture the pin and have no latch. Placeholder cells are tied to no pin. Nine bidirectional data cells each have their own enable cell one index below them. One valid-flag output cell is its own enable: when it holds 1 the pin is released to a weak pull-up. Two clock output cells drive their pins all the time, because they have no enable. In functional mode the core's data, enables, valid flag and clocks go straight to the pins. A high-impedance test mode turns off every enable.

Top module: `bscan_ring`

## Requirements
- R1: After reset the chain holds all zeros, so scan_out is 0. The update latches hold their safe values: every data enable 0, data values 0, valid cell 1 and clock cells 0.
- R2: Each clock with shf_en high and cap_en low moves every cell one index toward cell 0. scan_in enters cell 112 and scan_out always shows cell 0. A bit therefore reaches scan_out after the number of shift clocks equal to its cell index.
- R3: A capture loads in_pad into the input-only cells at indices 0 to 8, 27, 48 to 64 and 105 to 110. in_pad bit k goes to the k-th of these cells in rising index order.
- R4: A capture loads dq_pad_in bit j into that data pin's cell. Bits 0 to 8 use cells 83, 79, 71, 67, 47, 43, 37, 33 and 29, and each enable cell sits at the data cell index minus 1.
- R5: A capture loads the value of the parameter INT_CAP into each placeholder cell. Each enable cell loads its own update latch value. Cell 65 loads vld_core, and cells 74 and 75 load ck_core bits 0 and 1.
- R6: A clock with upd_en high copies the chain into the update latches. Without upd_en the latches, and so the test-mode pins, hold through any number of capture and shift clocks.
- R7: In mode 1 (external test) and mode 2 (clamp), dq_pad_out[j] equals the latch of data cell j and dq_pad_oe[j] equals the latch of its enable cell. An enable of 0 releases the pin.
- R8: In modes 1 and 2 the valid pin follows the latch of cell 65. A value of 0 drives the pin low (vld_pad_drv=1, vld_pad=0). A value of 1 leaves the pin undriven at a weak high level (vld_pad_drv=0, vld_pad=1).
- R9: In modes 1, 2 and 3, ck_pad equals the latches of cells 74 and 75. These outputs have no enable.
- R10: In mode 3 (high impedance) every dq_pad_oe is 0 and the valid pin is undriven at a weak high level, whatever the latches hold.
- R11: In mode 0 (functional), dq_pad_out, dq_pad_oe, vld_pad and ck_pad equal dq_core_out, dq_core_oe, vld_core and ck_core, with vld_pad_drv at 1, whatever the latches hold.
- R12: When cap_en and shf_en are high in the same clock, the capture takes place and the shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| mode | input | 2 | 0 functional, 1 external test, 2 clamp, 3 high impedance |
| scan_in | input | 1 | Serial data into cell 112 |
| scan_out | output | 1 | Serial data from cell 0 |
| in_pad | input | 33 | Values at the input-only pins |
| dq_pad_in | input | 9 | Values at the data pads |
| dq_core_out | input | 9 | Core data toward the pads |
| dq_core_oe | input | 9 | Core data enables |
| vld_core | input | 1 | Core valid flag |
| ck_core | input | 2 | Core output clocks |
| dq_pad_out | output | 9 | Data driven to the pads |
| dq_pad_oe | output | 9 | Pad output enables, 0 releases the pad |
| vld_pad | output | 1 | Valid pin level |
| vld_pad_drv | output | 1 | 1 when the valid pin is driven, 0 when it rests on the weak pull-up |
| ck_pad | output | 2 | Output clock pins |

## Verification
A capture appears on scan_out one clock edge after the strobe for cell 0. Cell i appears after a further i shift edges. The update latches, and the pins in any test mode, change one edge after the update strobe. A change of mode reaches the pins in the same cycle, with no register in between. The bench drives inputs on the falling edge and reads scan_out before each shift edge, so it rebuilds the whole captured vector bit by bit. It checks the pins one time unit after it sets the mode, once just before and once just after each update, and so matches every result to the edge it is due at.

// File: rtl/bscan_ring_pkg.sv
package bscan_ring_pkg;

    localparam int N_CELLS  = 113;
    localparam int N_DQ     = 9;
    localparam int N_CK     = 2;
    localparam int N_SPANS  = 4;
    localparam int VLD_CELL = 65;
    localparam int CK_CELL0 = 74;

    typedef int span_t [N_SPANS];
    localparam span_t IN_LO = '{0, 27, 48, 105};
    localparam span_t IN_HI = '{8, 27, 64, 110};

    typedef int dq_map_t [N_DQ];
    // data cell of pad bit j; its enable cell is one index below
    localparam dq_map_t DQ_CELL = '{83, 79, 71, 67, 47, 43, 37, 33, 29};

    function automatic int count_inputs();
        int n = 0;
        for (int r = 0; r < N_SPANS; r++) n += IN_HI[r] - IN_LO[r] + 1;
        return n;
    endfunction

    localparam int N_IN = count_inputs();

    typedef enum logic [1:0] {
        MODE_FUNC   = 2'd0,
        MODE_EXTEST = 2'd1,
        MODE_CLAMP  = 2'd2,
        MODE_HIGHZ  = 2'd3
    } scan_mode_e;

    typedef enum logic [2:0] {
        K_INTERNAL,
        K_INPUT,
        K_CTRL,
        K_DATA,
        K_VLD,
        K_CLKOUT
    } cell_kind_e;

    typedef struct packed {
        logic [N_DQ-1:0] data;
        logic [N_DQ-1:0] ctrl;
        logic            vld;
        logic [N_CK-1:0] ck;
    } latch_t;

    typedef struct packed {
        logic [N_DQ-1:0] out;
        logic [N_DQ-1:0] oe;
        logic            vld;
        logic            vld_drv;
        logic [N_CK-1:0] ck;
    } pad_drive_t;

    localparam latch_t SAFE_LATCH = '{data: '0, ctrl: '0, vld: 1'b1, ck: '0};

    function automatic cell_kind_e kind_of(input int idx);
        cell_kind_e k = K_INTERNAL;
        for (int r = 0; r < N_SPANS; r++)
            if (idx >= IN_LO[r] && idx <= IN_HI[r]) k = K_INPUT;
        for (int j = 0; j < N_DQ; j++) begin
            if (idx == DQ_CELL[j])          k = K_DATA;
            else if (idx == DQ_CELL[j] - 1) k = K_CTRL;
        end
        if (idx == VLD_CELL) k = K_VLD;
        if (idx >= CK_CELL0 && idx < CK_CELL0 + N_CK) k = K_CLKOUT;
        return k;
    endfunction

    function automatic int in_slot(input int idx);
        int base = 0;
        for (int r = 0; r < N_SPANS; r++) begin
            if (idx >= IN_LO[r] && idx <= IN_HI[r]) return base + idx - IN_LO[r];
            base += IN_HI[r] - IN_LO[r] + 1;
        end
        return 0;
    endfunction

    function automatic int dq_slot(input int idx);
        for (int j = 0; j < N_DQ; j++)
            if (idx == DQ_CELL[j] || idx == DQ_CELL[j] - 1) return j;
        return 0;
    endfunction

endpackage

// File: rtl/bscan_capture_sel.sv
module bscan_capture_sel
    import bscan_ring_pkg::*;
#(
    parameter logic INT_CAP = 1'b0
) (
    input  logic [N_IN-1:0]    in_pad,
    input  logic [N_DQ-1:0]    dq_pad_in,
    input  logic [N_DQ-1:0]    upd_ctrl,
    input  logic               vld_core,
    input  logic [N_CK-1:0]    ck_core,
    output logic [N_CELLS-1:0] cap_vec
);

    for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
        localparam cell_kind_e KND = kind_of(gi);
        if (KND == K_INPUT) begin : g_in
            localparam int SLOT = in_slot(gi);
            assign cap_vec[gi] = in_pad[SLOT];
        end else if (KND == K_DATA) begin : g_dat
            localparam int SLOT = dq_slot(gi);
            assign cap_vec[gi] = dq_pad_in[SLOT];
        end else if (KND == K_CTRL) begin : g_ctl
            localparam int SLOT = dq_slot(gi);
            assign cap_vec[gi] = upd_ctrl[SLOT];
        end else if (KND == K_VLD) begin : g_vld
            assign cap_vec[gi] = vld_core;
        end else if (KND == K_CLKOUT) begin : g_ck
            assign cap_vec[gi] = ck_core[gi - CK_CELL0];
        end else begin : g_int
            assign cap_vec[gi] = INT_CAP;
        end
    end

endmodule

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain
    import bscan_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               shf_en,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] cap_vec,
    output logic               scan_out,
    output latch_t             upd_src
);

    logic [N_CELLS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)         sr <= '0;
        else if (cap_en) sr <= cap_vec;
        else if (shf_en) sr <= {scan_in, sr[N_CELLS-1:1]};
    end

    assign scan_out = sr[0];

    for (genvar gj = 0; gj < N_DQ; gj++) begin : g_dq
        assign upd_src.data[gj] = sr[DQ_CELL[gj]];
        assign upd_src.ctrl[gj] = sr[DQ_CELL[gj] - 1];
    end
    assign upd_src.vld = sr[VLD_CELL];
    assign upd_src.ck  = sr[CK_CELL0 + N_CK - 1 : CK_CELL0];

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
        (shf_en && !cap_en) |=> (sr[N_CELLS-2:0] == $past(sr[N_CELLS-1:1])
                                 && sr[N_CELLS-1] == $past(scan_in)));

    assert_capture_wins_R12: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (sr == $past(cap_vec)));

endmodule

// File: rtl/bscan_update_reg.sv
module bscan_update_reg
    import bscan_ring_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_en,
    input  latch_t d,
    output latch_t q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= SAFE_LATCH;
        else if (upd_en) q <= d;
    end

    assert_safe_after_reset_R1: assert property (@(posedge clk)
        rst |=> (q == SAFE_LATCH));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(q));

    assert_latch_load_R6: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (q == $past(d)));

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_ring_pkg::*;
(
    input  scan_mode_e      mode,
    input  latch_t          upd,
    input  logic [N_DQ-1:0] core_out,
    input  logic [N_DQ-1:0] core_oe,
    input  logic            vld_core,
    input  logic [N_CK-1:0] ck_core,
    output pad_drive_t      pd
);

    always_comb begin
        pd.out     = upd.data;
        pd.oe      = upd.ctrl;
        pd.vld     = upd.vld;
        pd.vld_drv = ~upd.vld;
        pd.ck      = upd.ck;
        case (mode)
            MODE_FUNC: begin
                pd.out     = core_out;
                pd.oe      = core_oe;
                pd.vld     = vld_core;
                pd.vld_drv = 1'b1;
                pd.ck      = ck_core;
            end
            MODE_HIGHZ: begin
                pd.oe      = '0;
                pd.vld     = 1'b1;
                pd.vld_drv = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bscan_ring.sv
module bscan_ring
    import bscan_ring_pkg::*;
#(
    parameter logic INT_CAP = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cap_en,
    input  logic                          shf_en,
    input  logic                          upd_en,
    input  logic [1:0]                    mode,
    input  logic                          scan_in,
    output logic                          scan_out,
    input  logic [bscan_ring_pkg::N_IN-1:0] in_pad,
    input  logic [bscan_ring_pkg::N_DQ-1:0] dq_pad_in,
    input  logic [bscan_ring_pkg::N_DQ-1:0] dq_core_out,
    input  logic [bscan_ring_pkg::N_DQ-1:0] dq_core_oe,
    input  logic                          vld_core,
    input  logic [bscan_ring_pkg::N_CK-1:0] ck_core,
    output logic [bscan_ring_pkg::N_DQ-1:0] dq_pad_out,
    output logic [bscan_ring_pkg::N_DQ-1:0] dq_pad_oe,
    output logic                          vld_pad,
    output logic                          vld_pad_drv,
    output logic [bscan_ring_pkg::N_CK-1:0] ck_pad
);

    scan_mode_e         mode_e;
    logic [N_CELLS-1:0] cap_vec;
    latch_t             upd_src;
    latch_t             upd_q;
    pad_drive_t         pd;

    assign mode_e = scan_mode_e'(mode);

    bscan_capture_sel #(.INT_CAP(INT_CAP)) u_cap (
        .in_pad    (in_pad),
        .dq_pad_in (dq_pad_in),
        .upd_ctrl  (upd_q.ctrl),
        .vld_core  (vld_core),
        .ck_core   (ck_core),
        .cap_vec   (cap_vec)
    );

    bscan_shift_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .shf_en   (shf_en),
        .scan_in  (scan_in),
        .cap_vec  (cap_vec),
        .scan_out (scan_out),
        .upd_src  (upd_src)
    );

    bscan_update_reg u_upd (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .d      (upd_src),
        .q      (upd_q)
    );

    bscan_pad_mux u_mux (
        .mode     (mode_e),
        .upd      (upd_q),
        .core_out (dq_core_out),
        .core_oe  (dq_core_oe),
        .vld_core (vld_core),
        .ck_core  (ck_core),
        .pd       (pd)
    );

    assign dq_pad_out  = pd.out;
    assign dq_pad_oe   = pd.oe;
    assign vld_pad     = pd.vld;
    assign vld_pad_drv = pd.vld_drv;
    assign ck_pad      = pd.ck;

    assert_highz_released_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_HIGHZ) |-> (dq_pad_oe == '0 && !vld_pad_drv && vld_pad));

    assert_func_passthru_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_FUNC) |-> (dq_pad_out == dq_core_out && dq_pad_oe == dq_core_oe
                                   && ck_pad == ck_core && vld_pad_drv));

    assert_vld_weak_high_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_e != MODE_FUNC) |-> (vld_pad_drv != vld_pad));

    assert_clk_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_e != MODE_FUNC && !upd_en) |=> (mode_e == MODE_FUNC || $stable(ck_pad)));

endmodule

// File: tb/bscan_ring_tb.sv
module bscan_ring_tb;

    localparam int NC = 113;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0;
    logic [1:0]  mode = 2'd1;
    logic        scan_in = 1'b0;
    logic        scan_out;
    logic [32:0] in_pad = '0;
    logic [8:0]  dq_pad_in = '0, dq_core_out = '0, dq_core_oe = '0;
    logic        vld_core = 1'b0;
    logic [1:0]  ck_core = '0;
    logic [8:0]  dq_pad_out, dq_pad_oe;
    logic        vld_pad, vld_pad_drv;
    logic [1:0]  ck_pad;

    int total = 0;
    int bad = 0;

    int dqc [9] = '{83, 79, 71, 67, 47, 43, 37, 33, 29};

    logic [NC-1:0] exp_upd, exp_chain, got, pat;
    logic [NC-1:0] m_in, m_dat, m_oth;

    always #10 clk = ~clk;

    bscan_ring u_dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
        .mode(mode), .scan_in(scan_in), .scan_out(scan_out), .in_pad(in_pad),
        .dq_pad_in(dq_pad_in), .dq_core_out(dq_core_out), .dq_core_oe(dq_core_oe),
        .vld_core(vld_core), .ck_core(ck_core), .dq_pad_out(dq_pad_out),
        .dq_pad_oe(dq_pad_oe), .vld_pad(vld_pad), .vld_pad_drv(vld_pad_drv),
        .ck_pad(ck_pad)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic bit is_in_cell(input int i);
        return (i <= 8) || (i == 27) || (i >= 48 && i <= 64) || (i >= 105 && i <= 110);
    endfunction

    function automatic int dq_of(input int i, input int off);
        for (int j = 0; j < 9; j++) if (dqc[j] - off == i) return j;
        return -1;
    endfunction

    function automatic logic [NC-1:0] rand_vec();
        logic [127:0] t = {$urandom, $urandom, $urandom, $urandom};
        return t[NC-1:0];
    endfunction

    function automatic logic [NC-1:0] build_cap(input logic [NC-1:0] upd);
        logic [NC-1:0] v = '0;
        int k = 0;
        for (int i = 0; i < NC; i++) begin
            if (is_in_cell(i)) begin v[i] = in_pad[k]; k++; end
            else if (dq_of(i, 0) >= 0) v[i] = dq_pad_in[dq_of(i, 0)];
            else if (dq_of(i, 1) >= 0) v[i] = upd[i];
            else if (i == 65) v[i] = vld_core;
            else if (i == 74) v[i] = ck_core[0];
            else if (i == 75) v[i] = ck_core[1];
        end
        return v;
    endfunction

    task automatic shift_all(input logic [NC-1:0] p, output logic [NC-1:0] g);
        for (int i = 0; i < NC; i++) begin
            g[i] = scan_out;
            scan_in = p[i];
            shf_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        shf_en = 1'b0;
    endtask

    task automatic check_pins(input int m, input string ctx);
        logic [8:0] ed, ec;
        for (int j = 0; j < 9; j++) begin
            ed[j] = exp_upd[dqc[j]];
            ec[j] = exp_upd[dqc[j] - 1];
        end
        mode = 2'(m);
        #1;
        if (m == 0) begin
            chk({dq_pad_out, dq_pad_oe, vld_pad, vld_pad_drv, ck_pad} ==
                {dq_core_out, dq_core_oe, vld_core, 1'b1, ck_core},
                {"R11 ", ctx}, {dq_pad_out, dq_pad_oe, vld_pad, vld_pad_drv, ck_pad},
                {dq_core_out, dq_core_oe, vld_core, 1'b1, ck_core});
        end else begin
            if (m == 3) begin
                chk({dq_pad_oe, vld_pad, vld_pad_drv} == {9'b0, 2'b10}, {"R10 ", ctx},
                    {dq_pad_oe, vld_pad, vld_pad_drv}, {9'b0, 2'b10});
            end else begin
                chk({dq_pad_out, dq_pad_oe} == {ed, ec}, {"R7 ", ctx},
                    {dq_pad_out, dq_pad_oe}, {ed, ec});
                chk({vld_pad, vld_pad_drv} == {exp_upd[65], ~exp_upd[65]}, {"R8 ", ctx},
                    {vld_pad, vld_pad_drv}, {exp_upd[65], ~exp_upd[65]});
            end
            chk(ck_pad == exp_upd[75:74], {"R9 ", ctx}, ck_pad, exp_upd[75:74]);
        end
    endtask

    initial begin
        #3000000;
        $display("FAIL watchdog expired");
        total++;
        bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_in = '0; m_dat = '0;
        for (int i = 0; i < NC; i++) begin
            if (is_in_cell(i)) m_in[i] = 1'b1;
            if (dq_of(i, 0) >= 0) m_dat[i] = 1'b1;
        end
        m_oth = ~(m_in | m_dat);

        exp_upd = '0;
        exp_upd[65] = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of chain and latches
        chk(scan_out == 1'b0, "R1 scan_out", scan_out, 0);
        check_pins(1, "R1 safe pins");
        chk(dq_pad_oe == 9'b0 && !vld_pad_drv, "R1 released", {dq_pad_oe, vld_pad_drv}, 0);

        for (int it = 0; it < 24; it++) begin
            in_pad      = 33'(rand_vec());
            dq_pad_in   = 9'($urandom);
            dq_core_out = 9'($urandom);
            dq_core_oe  = 9'($urandom);
            vld_core    = 1'($urandom);
            ck_core     = 2'($urandom);
            if (it == 0)      pat = '1;
            else if (it == 1) pat = '0;
            else if (it == 2) begin pat = '0; pat[112] = 1'b1; pat[65] = 1'b1; end
            else              pat = rand_vec();

            // capture, with shift also raised on some passes (R12)
            exp_chain = build_cap(exp_upd);
            cap_en = 1'b1;
            shf_en = (it % 4 == 3);
            @(posedge clk);
            @(negedge clk);
            cap_en = 1'b0;
            shf_en = 1'b0;
            mode = 2'd1;

            shift_all(pat, got);
            chk(((got ^ exp_chain) & m_in) == '0,
                (it % 4 == 3) ? "R3 R12 input cells" : "R3 input cells", got & m_in, exp_chain & m_in);
            chk(((got ^ exp_chain) & m_dat) == '0,
                (it % 4 == 3) ? "R4 R12 data cells" : "R4 data cells", got & m_dat, exp_chain & m_dat);
            chk(((got ^ exp_chain) & m_oth) == '0, "R5 other cells", got & m_oth, exp_chain & m_oth);

            // R6: pins still show the old latches after capture and shifts
            check_pins(1, "R6 hold");

            upd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            upd_en = 1'b0;
            exp_upd = pat;

            check_pins(0, "func");
            check_pins(2, "clamp");
            check_pins(3, "highz");
            check_pins(1, "extest");

            // R2: shift the same pattern back in and read it out unchanged
            shift_all(pat, got);
            chk(got == pat, "R2 shift through", got, pat);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule